// File: doc/BRIEF.md
# Blinking Cursor Window Generator

This block decides, pixel by pixel during a display refresh, whether a rectangular hardware cursor covers the pixel now being drawn. The column and row counters of the refresh engine come in, and a single flag comes out. The flag is high when the pixel lies inside the cursor rectangle and the cursor is in its visible phase. A small register file holds the following settings:

- the top-left corner of the rectangle;
- its width and height, from 1 to 31 pixels each;
- a blink-enable bit;
- a 7-bit blink divisor.

While blinking is enabled, the cursor alternates between its visible and hidden phases. It switches phase once for every (divisor + 1) frame pulses.

The pixel counters and the output flag form a free-running pipeline with a fixed latency of one clock. There is no valid/ready handshake and no back-pressure. The refresh engine presents a new pixel position every clock. The flag for that position appears one clock later, so the engine delays its own pixel data by one stage to match. Register writes use a plain address, data, byte-enable and write-strobe bus. Reads are combinational.

Top module: `cursor_overlay`

## Requirements
- R1: The size register is at address 2. Cursor width is the 5-bit field in bits 12:8 and cursor height is the 5-bit field in bits 4:0. Each gives a size of 1 to 31 pixels.
- R2: When the width field or the height field is zero, cursor_vis stays low for every pixel.
- R3: After reset, reads return 0x0000 at address 0 (X position), 0x0000 at address 1 (Y position), 0x0101 at address 2 (width 1, height 1) and 0x007F at address 3 (blink disabled, divisor 127).
- R4: The blink register is at address 3, with enable in bit 7 and divisor in bits 6:0. While the enable bit is 0, the cursor is steadily visible.
- R5: While blinking is enabled, the phase starts visible. It toggles on every (divisor + 1)-th frame pulse.
- R6: A write that touches the low byte of the blink register restarts the frame-pulse count from zero. The phase is not toggled, even when a frame pulse arrives in the same cycle.
- R7: A pixel is inside the rectangle when X ≤ col < X + width and Y ≤ row < Y + height. X is bits 9:0 of address 0 and Y is bits 9:0 of address 1. The comparison is made without wrapping at 1024.
- R8: cursor_vis for the pixel presented in clock n is valid after the edge that ends clock n, which is one clock of latency.
- R9: reg_be[0] enables writing bits 7:0 and reg_be[1] enables writing bits 15:8. Bits that no field occupies read as zero.
- R10: Clearing the enable bit returns the pulse count to zero and the phase to visible. A later enable therefore starts a full visible half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address, used for both read and write |
| reg_be | input | 2 | Byte enables for a write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pix_col | input | 10 | Current pixel column |
| pix_row | input | 10 | Current pixel row |
| frame_pulse | input | 1 | One-clock pulse per refresh frame |
| cursor_vis | output | 1 | Cursor covers the pixel from the previous clock |

## Verification
The bench sweeps whole pixel grids for several cursor shapes and compares each output against the rectangle inequality computed in the bench. The shapes include a 1-by-1 cursor, a 31-wide cursor, zero width and zero height. A design with an inclusive right edge, a swapped field, or a missing zero-size check would show an extra or missing column or row.

One sweep puts the rectangle at the right edge of the coordinate space. A 10-bit sum there would wrap and blank the cursor. Blink runs count frame pulses against a model of the phase, including a divisor rewrite in the middle of a count and a disable/enable cycle. A design that toggles early, off by one pulse, or keeps a stale count would drift from the model.

Byte-enable writes and readbacks show any masked byte that was written anyway, and any unused bit that reads as non-zero.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 16;

  typedef enum logic [REG_AW-1:0] {
    ADR_XPOS  = 2'd0,
    ADR_YPOS  = 2'd1,
    ADR_SIZE  = 2'd2,
    ADR_BLINK = 2'd3
  } reg_adr_e;

  localparam logic [REG_DW-1:0] SIZE_RST  = 16'h0101;
  localparam logic [REG_DW-1:0] BLINK_RST = 16'h007F;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W = 10,
  parameter int unsigned DIM_W = 5,
  parameter int unsigned DIV_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [REG_AW-1:0]   addr,
  input  logic [1:0]          be,
  input  logic [REG_DW-1:0]   wdata,
  output logic [REG_DW-1:0]   rdata,
  output logic [POS_W-1:0]    pos_x,
  output logic [POS_W-1:0]    pos_y,
  output logic [DIM_W-1:0]    dim_w,
  output logic [DIM_W-1:0]    dim_h,
  output logic                blk_en,
  output logic [DIV_W-1:0]    blk_div,
  output logic                div_wr
);
  localparam int unsigned EN_BIT = DIV_W;

  logic [REG_DW-1:0] mask;
  logic [REG_DW-1:0] xpos_q, ypos_q, size_q, blink_q;
  logic [REG_DW-1:0] xpos_m, ypos_m, size_m, blink_m;

  always_comb begin
    mask = {{8{be[1]}}, {8{be[0]}}};
    // Per-register implemented bit masks: unused bits never store anything.
    xpos_m  = REG_DW'((1 << POS_W) - 1);
    ypos_m  = REG_DW'((1 << POS_W) - 1);
    size_m  = (REG_DW'((1 << DIM_W) - 1) << 8) | REG_DW'((1 << DIM_W) - 1);
    blink_m = REG_DW'((1 << (DIV_W + 1)) - 1);
  end

  function automatic logic [REG_DW-1:0] merge(input logic [REG_DW-1:0] old_v,
                                              input logic [REG_DW-1:0] impl);
    return ((old_v & ~mask) | (wdata & mask)) & impl;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xpos_q  <= '0;
      ypos_q  <= '0;
      size_q  <= SIZE_RST;
      blink_q <= BLINK_RST;
    end else if (we) begin
      unique case (reg_adr_e'(addr))
        ADR_XPOS:  xpos_q  <= merge(xpos_q, xpos_m);
        ADR_YPOS:  ypos_q  <= merge(ypos_q, ypos_m);
        ADR_SIZE:  size_q  <= merge(size_q, size_m);
        ADR_BLINK: blink_q <= merge(blink_q, blink_m);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_adr_e'(addr))
      ADR_XPOS:  rdata = xpos_q;
      ADR_YPOS:  rdata = ypos_q;
      ADR_SIZE:  rdata = size_q;
      ADR_BLINK: rdata = blink_q;
      default:   rdata = '0;
    endcase
  end

  assign pos_x   = xpos_q[POS_W-1:0];
  assign pos_y   = ypos_q[POS_W-1:0];
  assign dim_w   = size_q[8 +: DIM_W];
  assign dim_h   = size_q[DIM_W-1:0];
  assign blk_en  = blink_q[EN_BIT];
  assign blk_div = blink_q[DIV_W-1:0];
  assign div_wr  = we && (addr == ADR_BLINK) && be[0];

  // R9: a write with the low byte disabled leaves the low byte of the target intact
  p_lowbyte_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_SIZE && !be[0]) |=> $stable(size_q[7:0]));
  // R9: unused bits always read as zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q[15:13] == 3'b0) && (size_q[7:5] == 3'b0) && (blink_q[15:8] == 8'b0));
endmodule

// File: rtl/cursor_blink.sv
module cursor_blink #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic [DIV_W-1:0] blk_div,
  input  logic             div_wr,
  input  logic             frame_pulse,
  output logic             phase_on
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!blk_en) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (div_wr) begin
      cnt_q   <= '0;
    end else if (frame_pulse) begin
      if (cnt_q == blk_div) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_on = phase_q;

  // R4 / R10: disabled blinking forces the visible phase and a cleared count
  p_steady_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> (phase_q && cnt_q == '0));
  // R5: phase only moves on a frame pulse
  p_toggle_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && !frame_pulse) |=> $stable(phase_q));
  // R6: a divisor write restarts the count and holds the phase
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && div_wr) |=> (cnt_q == '0 && $stable(phase_q)));
  // R5: the count never passes the divisor
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= blk_div);
endmodule

// File: rtl/cursor_window.sv
module cursor_window #(
  parameter int unsigned POS_W = 10,
  parameter int unsigned DIM_W = 5
) (
  input  logic [POS_W-1:0] pos_x,
  input  logic [POS_W-1:0] pos_y,
  input  logic [DIM_W-1:0] dim_w,
  input  logic [DIM_W-1:0] dim_h,
  input  logic [POS_W-1:0] col,
  input  logic [POS_W-1:0] row,
  output logic             hit
);
  localparam int unsigned SUM_W = POS_W + 1;

  logic [SUM_W-1:0] x_end, y_end;
  logic             in_x, in_y, sized;

  always_comb begin
    x_end = SUM_W'(pos_x) + SUM_W'(dim_w);
    y_end = SUM_W'(pos_y) + SUM_W'(dim_h);
    in_x  = (col >= pos_x) && (SUM_W'(col) < x_end);
    in_y  = (row >= pos_y) && (SUM_W'(row) < y_end);
    sized = (dim_w != '0) && (dim_h != '0);
    hit   = sized && in_x && in_y;
  end

  // R2: a zero dimension never produces a hit
  always_comb begin
    p_zero_size_r2: assert ((dim_w != '0 && dim_h != '0) || !hit);
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W = 10,
  parameter int unsigned DIM_W = 5,
  parameter int unsigned DIV_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [1:0]          reg_be,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic [POS_W-1:0]    pix_col,
  input  logic [POS_W-1:0]    pix_row,
  input  logic                frame_pulse,
  output logic                cursor_vis
);
  logic [POS_W-1:0] pos_x, pos_y;
  logic [DIM_W-1:0] dim_w, dim_h;
  logic [DIV_W-1:0] blk_div;
  logic             blk_en, div_wr, phase_on, hit, vis_q;

  cursor_regs #(.POS_W(POS_W), .DIM_W(DIM_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .be(reg_be),
    .wdata(reg_wdata), .rdata(reg_rdata), .pos_x(pos_x), .pos_y(pos_y),
    .dim_w(dim_w), .dim_h(dim_h), .blk_en(blk_en), .blk_div(blk_div),
    .div_wr(div_wr)
  );

  cursor_blink #(.DIV_W(DIV_W)) u_blink (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .blk_div(blk_div),
    .div_wr(div_wr), .frame_pulse(frame_pulse), .phase_on(phase_on)
  );

  cursor_window #(.POS_W(POS_W), .DIM_W(DIM_W)) u_win (
    .pos_x(pos_x), .pos_y(pos_y), .dim_w(dim_w), .dim_h(dim_h),
    .col(pix_col), .row(pix_row), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vis_q <= 1'b0;
    else        vis_q <= hit && (phase_on || !blk_en);
  end

  assign cursor_vis = vis_q;

  // R8: the flag reflects the hit of the pixel from the previous clock
  p_vis_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_vis |-> $past(hit));
  // R4: with blinking off, a hit is always shown one clock later
  p_steady_show_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !blk_en) |=> cursor_vis);
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  pix_col = '0;
  logic [9:0]  pix_row = '0;
  logic        frame_pulse = 1'b0;
  logic        cursor_vis;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_ph = 1'b1;
  int m_div = 127;
  bit m_en = 1'b0;

  always #5 clk = ~clk;

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_col(pix_col), .pix_row(pix_row), .frame_pulse(frame_pulse),
    .cursor_vis(cursor_vis)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int be, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_be = 2'(be); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 3 && (be & 1)) begin
      m_div = d & 8'h7f; m_en = d[7]; m_cnt = 0;
      if (!m_en) m_ph = 1'b1;
    end
  endtask

  task automatic rd(input string req, input int a, input int exp);
    @(negedge clk);
    reg_addr = 2'(a);
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  // Sweep a window of pixels; expected hit computed arithmetically
  task automatic sweep(input string req, input int x, input int y, input int w,
                       input int h, input int c0, input int r0, input int n);
    for (int r = r0; r < r0 + n; r++) begin
      for (int c = c0; c < c0 + n; c++) begin
        @(negedge clk);
        if (r > r0 || c > c0) begin
          automatic int pc = (c == c0) ? c0 + n - 1 : c - 1;
          automatic int pr = (c == c0) ? r - 1 : r;
          automatic bit e = (w != 0) && (h != 0) && pc >= x && pc < x + w &&
                            pr >= y && pr < y + h;
          chk(req, int'(cursor_vis), int'(e));
        end
        pix_col = 10'(c); pix_row = 10'(r);
      end
    end
  endtask

  task automatic pulse(input string req);
    @(negedge clk);
    frame_pulse = 1'b1;
    @(negedge clk);
    frame_pulse = 1'b0;
    if (m_en) begin
      if (m_cnt == m_div) begin m_cnt = 0; m_ph = ~m_ph; end
      else m_cnt++;
    end
    @(negedge clk);
    chk(req, int'(cursor_vis), int'(m_ph || !m_en));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk); #1;
    chk("R8 reset vis", int'(cursor_vis), 0);
    rst_n = 1'b1;
    // R3 reset values
    rd("R3 xpos", 0, 16'h0000);
    rd("R3 ypos", 1, 16'h0000);
    rd("R3 size", 2, 16'h0101);
    rd("R3 blink", 3, 16'h007F);
    // R9 byte enables and unused bits
    wr(0, 2'b10, 16'hFFFF);
    rd("R9 high byte only", 0, 16'h0300);
    wr(0, 2'b01, 16'hFFFF);
    rd("R9 both bytes", 0, 16'h03FF);
    wr(2, 2'b01, 16'hFFFF);
    rd("R9 size low byte", 2, 16'h011F);
    wr(2, 2'b11, 16'hFFFF);
    rd("R1 size all ones", 2, 16'h1F1F);
    wr(3, 2'b11, 16'hFFFF);
    rd("R9 blink unused", 3, 16'h00FF);
    wr(3, 2'b11, 16'h007F);
    // R7 / R8 default 1x1 cursor at origin
    wr(0, 3, 0); wr(1, 3, 0);
    wr(2, 3, 16'h0101);
    sweep("R8 1x1 at origin", 0, 0, 1, 1, 0, 0, 6);
    // R1 / R7 general rectangle
    wr(0, 3, 5); wr(1, 3, 7); wr(2, 3, 16'h0603);
    sweep("R7 6x3 at 5,7", 5, 7, 6, 3, 0, 0, 20);
    // R1 maximum width and height
    wr(0, 3, 2); wr(1, 3, 1); wr(2, 3, 16'h1F1F);
    sweep("R1 31x31", 2, 1, 31, 31, 0, 0, 36);
    // R2 zero width / zero height
    wr(2, 3, 16'h0005);
    sweep("R2 zero width", 2, 1, 0, 5, 0, 0, 12);
    wr(2, 3, 16'h0500);
    sweep("R2 zero height", 2, 1, 5, 0, 0, 0, 12);
    // R7 no wrap at the coordinate edge
    wr(0, 3, 1010); wr(1, 3, 1015); wr(2, 3, 16'h1414);
    sweep("R7 edge no wrap", 1010, 1015, 20, 20, 1000, 1000, 24);
    // Blink: hold a covered pixel
    wr(0, 3, 4); wr(1, 3, 4); wr(2, 3, 16'h0202);
    @(negedge clk); pix_col = 10'd4; pix_row = 10'd4;
    for (int i = 0; i < 3; i++) pulse("R4 steady while disabled");
    wr(3, 3, 16'h0082);              // enable, divisor 2
    for (int i = 0; i < 12; i++) pulse("R5 toggle every div+1");
    wr(3, 3, 16'h0080);              // divisor 0: toggle each pulse
    for (int i = 0; i < 5; i++) pulse("R5 divisor zero");
    wr(3, 3, 16'h0083);              // divisor 3
    pulse("R6 count"); pulse("R6 count");
    wr(3, 1, 16'h0083);              // rewrite restarts count
    for (int i = 0; i < 8; i++) pulse("R6 restart");
    // R6 divisor write coinciding with a frame pulse
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd3; reg_be = 2'b01; reg_wdata = 16'h0081;
    frame_pulse = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; frame_pulse = 1'b0;
    m_div = 1; m_cnt = 0;
    @(negedge clk);
    chk("R6 write beats pulse", int'(cursor_vis), int'(m_ph));
    for (int i = 0; i < 4; i++) pulse("R6 after collision");
    // R10 disable and re-enable
    wr(3, 3, 16'h0081);
    pulse("R10 pre"); pulse("R10 pre");
    wr(3, 3, 16'h0001);
    @(negedge clk);
    chk("R10 visible after disable", int'(cursor_vis), 1);
    wr(3, 3, 16'h0081);
    for (int i = 0; i < 6; i++) pulse("R10 full half-period");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule